// File: doc/BRIEF.md
# Software-Triggered Reset Request Register

This block is a write-to-trigger control register on a simple register bus. Software stores a word to one 8-byte-aligned physical address, and the block turns the low trigger bits of that word into a single reset request. The request is one of three kinds: a chip-wide warm reset, an externally initiated reset aimed at the cores enabled in a steering mask, or a debug reset. The debug reset drives the same warm-reset action and also flags its own cause. Each request leaves the block as a one-cycle pulse on its own output, one clock after the store. A load from the register always returns zero, because the request has already been issued and the register holds nothing.

A small state machine sits at the centre of the block. Its states are `ST_IDLE` (no activity), `ST_WARM` (warm pulse out), `ST_EXT` (external pulse and target mask out), `ST_DBG` (warm and debug pulses out) and `ST_RESP` (read response out). Every state returns to `ST_IDLE` on the next clock unless that clock brings a new command. The transitions are taken from the decoded command, whatever the current state is: a warm store goes to `ST_WARM`, an external store to `ST_EXT`, a debug store to `ST_DBG`, a read to `ST_RESP`, and anything else to `ST_IDLE`. Back-to-back accesses are therefore accepted on every cycle.

Top module: `rstreq_ctrl`

## Requirements
- R1: Only accesses whose address lies in 0x89_0000_0808 to 0x89_0000_080F are claimed. A store or load at any other address causes no pulse and no `bus_rvalid`.
- R2: A claimed load with no store in the same cycle raises `bus_rvalid` for exactly one cycle, on the clock after `bus_rd`, with `bus_rdata` equal to zero.
- R3: A claimed store with data bit 0 set raises `warm_pulse` on the clock after the store. `ext_pulse` and `dbg_pulse` stay low.
- R4: A claimed store whose highest-priority trigger is data bit 1 raises `ext_pulse` on the clock after the store. In that same cycle, `ext_targets` equals the `steer_mask` value present during the store. At all other times `ext_targets` is zero.
- R5: A claimed store whose only trigger is data bit 3 raises both `warm_pulse` and `dbg_pulse` on the clock after the store, and leaves `ext_pulse` low.
- R6: When several trigger bits are set, bit 0 wins over bit 1, and bit 1 wins over bit 3. Exactly one request kind is issued.
- R7: Data bit 2 and bits 63:4 have no effect. A claimed store with none of bits 0, 1 or 3 set produces no pulse.
- R8: After a single store, each pulse output is high for exactly one cycle and then returns low.
- R9: A claimed load and a claimed store in the same cycle act as the store alone, and no `bus_rvalid` follows.
- R10: While `rst_n` is low, and on the first clock after it rises with an idle bus, all pulse outputs, `ext_targets` and `bus_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 40 | Physical byte address |
| bus_wr | input | 1 | Store strobe |
| bus_rd | input | 1 | Load strobe |
| bus_wdata | input | 64 | Store data |
| bus_rdata | output | 64 | Load data, always zero |
| bus_rvalid | output | 1 | Load data valid, one cycle after a claimed load |
| steer_mask | input | 8 | Per-core enable for the external reset |
| warm_pulse | output | 1 | Chip-wide warm reset request pulse |
| ext_pulse | output | 1 | External reset request pulse |
| ext_targets | output | 8 | Cores targeted by `ext_pulse` |
| dbg_pulse | output | 1 | Debug reset cause pulse, paired with `warm_pulse` |

## Verification
The load response and the reset trigger can land in the same cycle when software issues a load and a store to the register together. The bench drives `bus_rd` and `bus_wr` high on one edge with an external-reset data word. It then judges that the following cycle shows `ext_pulse` with the steered mask while `bus_rvalid` stays low. Multi-bit trigger words are also driven so that the priority resolution can be seen at the pulse outputs.

// File: rtl/rstreq_pkg.sv
package rstreq_pkg;

    // Trigger bit positions inside the stored word (software-visible).
    localparam int unsigned TRIG_WARM_BIT = 0;
    localparam int unsigned TRIG_EXT_BIT  = 1;
    localparam int unsigned TRIG_DBG_BIT  = 3;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WARM,
        CMD_EXT,
        CMD_DBG,
        CMD_READ
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WARM,
        ST_EXT,
        ST_DBG,
        ST_RESP
    } state_e;

endpackage

// File: rtl/rstreq_decode.sv
module rstreq_decode
    import rstreq_pkg::*;
#(
    parameter int unsigned  ADDR_W    = 40,
    parameter int unsigned  DATA_W    = 64,
    parameter logic [39:0]  BASE_ADDR = 40'h89_0000_0808
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output cmd_e              cmd
);

    localparam int unsigned LINE_LSB = 3;

    logic [ADDR_W-1:0] base_full;
    assign base_full = ADDR_W'(BASE_ADDR);

    // Any byte of the 8-byte word is claimed.
    assign hit = (addr[ADDR_W-1:LINE_LSB] == base_full[ADDR_W-1:LINE_LSB]);

    // Fixed priority: warm, then external, then debug; a store hides a read.
    always_comb begin
        cmd = CMD_NONE;
        if (hit && wr) begin
            if (wdata[TRIG_WARM_BIT])     cmd = CMD_WARM;
            else if (wdata[TRIG_EXT_BIT]) cmd = CMD_EXT;
            else if (wdata[TRIG_DBG_BIT]) cmd = CMD_DBG;
            else                          cmd = CMD_NONE;
        end else if (hit && rd) begin
            cmd = CMD_READ;
        end
    end

    logic unused_bits;
    assign unused_bits = ^{addr[LINE_LSB-1:0], wdata[DATA_W-1:4], wdata[2]};

endmodule

// File: rtl/rstreq_fsm.sv
module rstreq_fsm
    import rstreq_pkg::*;
#(
    parameter int unsigned NCORE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic [NCORE-1:0] steer_mask,
    output logic             warm_pulse,
    output logic             ext_pulse,
    output logic             dbg_pulse,
    output logic             rvalid,
    output logic [NCORE-1:0] ext_targets
);

    state_e           state_q, state_d;
    logic [NCORE-1:0] mask_q;

    // Next-state selection: every state follows the incoming command.
    always_comb begin
        unique case (cmd)
            CMD_WARM: state_d = ST_WARM;
            CMD_EXT:  state_d = ST_EXT;
            CMD_DBG:  state_d = ST_DBG;
            CMD_READ: state_d = ST_RESP;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and steering capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= (cmd == CMD_EXT) ? steer_mask : '0;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        warm_pulse  = 1'b0;
        ext_pulse   = 1'b0;
        dbg_pulse   = 1'b0;
        rvalid      = 1'b0;
        ext_targets = '0;
        unique case (state_q)
            ST_WARM: warm_pulse = 1'b1;
            ST_EXT: begin
                ext_pulse   = 1'b1;
                ext_targets = mask_q;
            end
            ST_DBG: begin
                warm_pulse = 1'b1;
                dbg_pulse  = 1'b1;
            end
            ST_RESP: rvalid = 1'b1;
            default: ;
        endcase
    end

    // R6: at most one request kind leaves the block in any cycle.
    a_r6_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_pulse, warm_pulse & ~dbg_pulse, dbg_pulse, rvalid}));

    // R4: targets are the mask seen during the accepted store.
    a_r4_targets: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pulse |-> (ext_targets == $past(steer_mask)));

endmodule

// File: rtl/rstreq_ctrl.sv
module rstreq_ctrl
    import rstreq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 40,
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned NCORE     = 8,
    parameter logic [39:0] BASE_ADDR = 40'h89_0000_0808
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [NCORE-1:0]  steer_mask,
    output logic              warm_pulse,
    output logic              ext_pulse,
    output logic [NCORE-1:0]  ext_targets,
    output logic              dbg_pulse
);

    logic hit;
    cmd_e cmd;

    rstreq_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .hit   (hit),
        .cmd   (cmd)
    );

    rstreq_fsm #(
        .NCORE (NCORE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .steer_mask  (steer_mask),
        .warm_pulse  (warm_pulse),
        .ext_pulse   (ext_pulse),
        .dbg_pulse   (dbg_pulse),
        .rvalid      (bus_rvalid),
        .ext_targets (ext_targets)
    );

    // The register holds nothing once a request is issued.
    assign bus_rdata = '0;

    // R2: read data seen with a valid response is zero.
    a_r2_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata == '0));

    // R1: an unclaimed access causes no response.
    a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !(warm_pulse || ext_pulse || dbg_pulse || bus_rvalid));

    // R3, R6: bit 0 always produces a plain warm request.
    a_r3_warm_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr && bus_wdata[TRIG_WARM_BIT])
            |=> (warm_pulse && !ext_pulse && !dbg_pulse));

    // R9: a store hides a simultaneous load.
    a_r9_store_first: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_wr) |=> !bus_rvalid);

endmodule

// File: tb/sim_rstreq_ctrl.sv
module sim_rstreq_ctrl;

    localparam logic [39:0] BASE = 40'h89_0000_0808;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  steer_mask = '0;
    logic        warm_pulse, ext_pulse, dbg_pulse;
    logic [7:0]  ext_targets;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rstreq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .steer_mask(steer_mask),
        .warm_pulse(warm_pulse), .ext_pulse(ext_pulse),
        .ext_targets(ext_targets), .dbg_pulse(dbg_pulse)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Packed view of outputs: {warm, ext, dbg, rvalid, targets}.
    function automatic logic [11:0] outs();
        return {warm_pulse, ext_pulse, dbg_pulse, bus_rvalid, ext_targets};
    endfunction

    // Drive one access; return outputs on the following cycle and the one after.
    task automatic access(input logic wr, input logic rd, input logic [39:0] a,
                          input logic [63:0] d, input logic [7:0] m,
                          output logic [11:0] o1, output logic [11:0] o2);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; steer_mask = m;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; steer_mask = 8'h00;
        o1 = outs();
        @(negedge clk);
        o2 = outs();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R10 during reset", 64'(outs()), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", 64'(outs()), 64'h0);
    endtask

    task automatic t_read();
        logic [11:0] o1, o2;
        access(1'b0, 1'b1, BASE, '0, 8'h00, o1, o2);
        check("R2 rvalid", 64'(o1), 64'h100);
        check("R2 rdata", bus_rdata, 64'h0);
        check("R2 single", 64'(o2), 64'h0);
    endtask

    task automatic t_warm();
        logic [11:0] o1, o2;
        access(1'b1, 1'b0, BASE, 64'h1, 8'h3C, o1, o2);
        check("R3 warm", 64'(o1), 64'h800);
        check("R8 warm one cycle", 64'(o2), 64'h0);
    endtask

    task automatic t_ext();
        logic [11:0] o1, o2;
        access(1'b1, 1'b0, BASE + 40'd4, 64'h2, 8'hA5, o1, o2);
        check("R4 ext and targets", 64'(o1), 64'h4A5);
        check("R8 ext one cycle", 64'(o2), 64'h0);
    endtask

    task automatic t_dbg();
        logic [11:0] o1, o2;
        access(1'b1, 1'b0, BASE, 64'h8, 8'hFF, o1, o2);
        check("R5 dbg with warm", 64'(o1), 64'hA00);
        check("R8 dbg one cycle", 64'(o2), 64'h0);
    endtask

    task automatic t_prio();
        logic [11:0] o1, o2;
        access(1'b1, 1'b0, BASE, 64'hB, 8'h11, o1, o2);
        check("R6 bit0 wins", 64'(o1), 64'h800);
        access(1'b1, 1'b0, BASE, 64'hA, 8'h42, o1, o2);
        check("R6 bit1 over bit3", 64'(o1), 64'h442);
    endtask

    task automatic t_ignore();
        logic [11:0] o1, o2;
        access(1'b1, 1'b0, BASE, 64'hFFFF_FFFF_FFFF_FFF4, 8'hFF, o1, o2);
        check("R7 ignored bits", 64'(o1), 64'h0);
        access(1'b1, 1'b0, BASE, 64'h0, 8'hFF, o1, o2);
        check("R7 zero store", 64'(o1), 64'h0);
    endtask

    task automatic t_miss();
        logic [11:0] o1, o2;
        access(1'b1, 1'b0, BASE + 40'd8, 64'h1, 8'h00, o1, o2);
        check("R1 above range", 64'(o1), 64'h0);
        access(1'b0, 1'b1, BASE - 40'd1, 64'h0, 8'h00, o1, o2);
        check("R1 read below range", 64'(o1), 64'h0);
        access(1'b1, 1'b0, BASE + 40'd7, 64'h1, 8'h00, o1, o2);
        check("R1 last byte claimed", 64'(o1), 64'h800);
    endtask

    task automatic t_collide();
        logic [11:0] o1, o2;
        access(1'b1, 1'b1, BASE, 64'h2, 8'h5A, o1, o2);
        check("R9 store wins", 64'(o1), 64'h45A);
        check("R9 no late rvalid", 64'(o2), 64'h0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_read();
                t_warm();
                t_ext();
                t_dbg();
                t_prio();
                t_ignore();
                t_miss();
                t_collide();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule